// File: doc/BRIEF.md
# Flash Patch Address Comparator

This block watches the processor's accesses to the code region and compares each one against a bank of programmable word addresses. There are two groups of comparators. Six of them respond only to instruction fetches. Two of them respond only to literal (data) loads. Each comparator has an enable, a match address and a mode bit.

When a comparator in remap mode hits, the block returns an address in system space in place of the code address. That address is a slot in a remap area, chosen by the comparator's index. When a comparator in breakpoint mode hits, the block raises a one-cycle breakpoint request to the core instead, and the address passes through unchanged. A global enable gates all of this. The remap memory and the core's halt logic sit outside the block. All registers are loaded through a write-only port.

The result path is controlled by a two-state machine. `S_IDLE` means no result is presented. `S_RESULT` means the registered result of the previous cycle's access is on the outputs. The state moves as follows:
- **start** (`S_IDLE` to `S_RESULT`) when `acc_valid` is sampled high;
- **stream** (`S_RESULT` to `S_RESULT`) on a back-to-back strobe;
- **drain** (`S_RESULT` to `S_IDLE`) when no strobe arrives;
- **wait** (`S_IDLE` to `S_IDLE`) otherwise.

Top module: `fpatch_cmp`

## Requirements
- R1: After reset `glb_en` is 0, `res_valid` is 0, every comparator is disabled, and the remap base is 0.
- R2: `res_valid` is 1 in exactly the cycle that follows each cycle in which `acc_valid` is sampled high. Back-to-back strobes give back-to-back results, each carrying the result of its own access.
- R3: Comparators 0 to 5 match only accesses with `acc_is_lit`=0 (fetch). Comparators 6 and 7 match only accesses with `acc_is_lit`=1 (literal load).
- R4: A comparator matches when `acc_addr[31:2]` equals its stored word address. Bits [1:0] of the access are ignored.
- R5: On a remap-mode hit, `remap_hit`=1 and `res_addr` = remap base + 4 × comparator index + `acc_addr[1:0]`. The remap base always has bits [4:0] equal to zero.
- R6: On a breakpoint-mode hit, `bkpt_pulse`=1 for one cycle, `remap_hit`=0, and `res_addr` equals the access address.
- R7: Accesses at or above 0x2000_0000 (outside the code region) never hit.
- R8: When several enabled comparators of the access's group match, the one with the lowest index decides both the remap slot and the mode.
- R9: While `glb_en` is 0, no access remaps or raises a breakpoint.
- R10: A write with `wr_en`=1 decodes `wr_idx` as follows:
  - 0 to 7 load comparator `wr_idx` with `wr_data[31:2]` as the match word, `wr_data[1]` as the mode (1 = breakpoint) and `wr_data[0]` as the enable.
  - 8 loads the remap base from `wr_data[31:5]`.
  - 9 loads `glb_en` from `wr_data[0]`.
  - Indices 10 to 15 change nothing.
- R11: An access with no hit returns `res_addr` equal to the access address, with `remap_hit`=0 and `bkpt_pulse`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 4 | Register select |
| wr_data | input | 32 | Register write data |
| acc_valid | input | 1 | Access present this cycle |
| acc_is_lit | input | 1 | 1 = literal load, 0 = instruction fetch |
| acc_addr | input | 32 | Access byte address |
| res_valid | output | 1 | Result present |
| res_addr | output | 32 | Remapped or original address |
| remap_hit | output | 1 | Access was redirected |
| bkpt_pulse | output | 1 | Breakpoint request |
| glb_en | output | 1 | Global enable state |

## Verification
The bench builds the block with its default values: six fetch comparators, two literal comparators, a 32-bit address and the code region ending at 0x2000_0000. With only eight comparators, it can sweep every comparator index against both access types and all four byte offsets, in both remap and breakpoint mode. Stacking every comparator on one address then exposes the whole priority chain as the comparators are disabled one at a time. The region boundary, the global gate and the unused write indices are probed directly at their edges.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

    typedef enum logic [0:0] {
        S_IDLE   = 1'b0,
        S_RESULT = 1'b1
    } res_state_t;

    localparam int unsigned CFG_EN_BIT   = 0;
    localparam int unsigned CFG_MODE_BIT = 1;
    localparam int unsigned CTL_GLB_BIT  = 0;

endpackage

// File: rtl/fpc_regs.sv
module fpc_regs #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned N_CMP  = 8,
    parameter int unsigned IDX_W  = 4,
    parameter int unsigned BASE_W = 27
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [IDX_W-1:0]                  wr_idx,
    input  logic [ADDR_W-1:0]                 wr_data,
    output logic [N_CMP-1:0]                  cmp_en,
    output logic [N_CMP-1:0]                  cmp_bk,
    output logic [N_CMP-1:0][ADDR_W-3:0]      cmp_word,
    output logic [BASE_W-1:0]                 base_hi,
    output logic                              glb_en
);
    import fpc_pkg::*;

    localparam logic [IDX_W-1:0] BASE_SEL = IDX_W'(N_CMP);
    localparam logic [IDX_W-1:0] CTL_SEL  = IDX_W'(N_CMP + 1);

    for (genvar i = 0; i < N_CMP; i++) begin : g_cfg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cmp_en[i]   <= 1'b0;
                cmp_bk[i]   <= 1'b0;
                cmp_word[i] <= '0;
            end else if (wr_en && wr_idx == IDX_W'(i)) begin
                cmp_en[i]   <= wr_data[CFG_EN_BIT];
                cmp_bk[i]   <= wr_data[CFG_MODE_BIT];
                cmp_word[i] <= wr_data[ADDR_W-1:2];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_hi <= '0;
            glb_en  <= 1'b0;
        end else if (wr_en) begin
            if (wr_idx == BASE_SEL) base_hi <= wr_data[ADDR_W-1:ADDR_W-BASE_W];
            if (wr_idx == CTL_SEL)  glb_en  <= wr_data[CTL_GLB_BIT];
        end
    end

endmodule

// File: rtl/fpc_match.sv
module fpc_match #(
    parameter int unsigned         ADDR_W   = 32,
    parameter int unsigned         N_INSN   = 6,
    parameter int unsigned         N_CMP    = 8,
    parameter int unsigned         SEL_W    = 3,
    parameter logic [ADDR_W-1:0]   CODE_TOP = 32'h2000_0000
) (
    input  logic                          acc_is_lit,
    input  logic [ADDR_W-1:0]             acc_addr,
    input  logic [N_CMP-1:0]              cmp_en,
    input  logic [N_CMP-1:0]              cmp_bk,
    input  logic [N_CMP-1:0][ADDR_W-3:0]  cmp_word,
    output logic                          any_hit,
    output logic [SEL_W-1:0]              win_idx,
    output logic                          win_bk
);
    logic             in_code;
    logic [N_CMP-1:0] hit_vec;

    assign in_code = acc_addr < CODE_TOP;

    for (genvar i = 0; i < N_CMP; i++) begin : g_cmp
        if (i < N_INSN) begin : g_fetch
            assign hit_vec[i] = cmp_en[i] && !acc_is_lit && in_code &&
                                (cmp_word[i] == acc_addr[ADDR_W-1:2]);
        end else begin : g_lit
            assign hit_vec[i] = cmp_en[i] && acc_is_lit && in_code &&
                                (cmp_word[i] == acc_addr[ADDR_W-1:2]);
        end
    end

    always_comb begin
        any_hit = 1'b0;
        win_idx = '0;
        win_bk  = 1'b0;
        for (int i = N_CMP - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                any_hit = 1'b1;
                win_idx = SEL_W'(i);
                win_bk  = cmp_bk[i];
            end
        end
    end

endmodule

// File: rtl/fpc_ctrl.sv
module fpc_ctrl #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned SEL_W  = 3,
    parameter int unsigned BASE_W = 27
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                acc_valid,
    input  logic [ADDR_W-1:0]   acc_addr,
    input  logic                any_hit,
    input  logic [SEL_W-1:0]    win_idx,
    input  logic                win_bk,
    input  logic                glb_en,
    input  logic [BASE_W-1:0]   base_hi,
    output logic                res_valid,
    output logic [ADDR_W-1:0]   res_addr,
    output logic                remap_hit,
    output logic                bkpt_pulse
);
    import fpc_pkg::*;

    res_state_t         state_q;
    logic               remap_q;
    logic               bk_q;
    logic [ADDR_W-1:0]  addr_q;
    logic               take_remap;
    logic               take_bk;

    assign take_remap = glb_en && any_hit && !win_bk;
    assign take_bk    = glb_en && any_hit && win_bk;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            unique case (state_q)
                S_IDLE:   if (acc_valid)  state_q <= S_RESULT;
                S_RESULT: if (!acc_valid) state_q <= S_IDLE;
                default:  state_q <= S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remap_q <= 1'b0;
            bk_q    <= 1'b0;
            addr_q  <= '0;
        end else if (acc_valid) begin
            remap_q <= take_remap;
            bk_q    <= take_bk;
            addr_q  <= take_remap ? {base_hi, win_idx, acc_addr[1:0]} : acc_addr;
        end
    end

    always_comb begin
        res_valid  = 1'b0;
        remap_hit  = 1'b0;
        bkpt_pulse = 1'b0;
        res_addr   = addr_q;
        unique case (state_q)
            S_IDLE: begin
                res_valid = 1'b0;
            end
            S_RESULT: begin
                res_valid  = 1'b1;
                remap_hit  = remap_q;
                bkpt_pulse = bk_q;
            end
            default: begin
                res_valid = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/fpatch_cmp.sv
module fpatch_cmp #(
    parameter int unsigned        ADDR_W   = 32,
    parameter int unsigned        N_INSN   = 6,
    parameter int unsigned        N_LIT    = 2,
    parameter logic [ADDR_W-1:0]  CODE_TOP = 32'h2000_0000
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   wr_en,
    input  logic [$clog2(N_INSN+N_LIT+2)-1:0]      wr_idx,
    input  logic [ADDR_W-1:0]                      wr_data,
    input  logic                                   acc_valid,
    input  logic                                   acc_is_lit,
    input  logic [ADDR_W-1:0]                      acc_addr,
    output logic                                   res_valid,
    output logic [ADDR_W-1:0]                      res_addr,
    output logic                                   remap_hit,
    output logic                                   bkpt_pulse,
    output logic                                   glb_en
);
    localparam int unsigned N_CMP  = N_INSN + N_LIT;
    localparam int unsigned IDX_W  = $clog2(N_CMP + 2);
    localparam int unsigned SEL_W  = (N_CMP > 1) ? $clog2(N_CMP) : 1;
    localparam int unsigned BASE_W = ADDR_W - SEL_W - 2;

    logic [N_CMP-1:0]              cmp_en;
    logic [N_CMP-1:0]              cmp_bk;
    logic [N_CMP-1:0][ADDR_W-3:0]  cmp_word;
    logic [BASE_W-1:0]             base_hi;
    logic                          any_hit;
    logic [SEL_W-1:0]              win_idx;
    logic                          win_bk;

    fpc_regs #(
        .ADDR_W(ADDR_W), .N_CMP(N_CMP), .IDX_W(IDX_W), .BASE_W(BASE_W)
    ) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .cmp_en(cmp_en), .cmp_bk(cmp_bk),
        .cmp_word(cmp_word), .base_hi(base_hi), .glb_en(glb_en)
    );

    fpc_match #(
        .ADDR_W(ADDR_W), .N_INSN(N_INSN), .N_CMP(N_CMP),
        .SEL_W(SEL_W), .CODE_TOP(CODE_TOP)
    ) match_i (
        .acc_is_lit(acc_is_lit), .acc_addr(acc_addr), .cmp_en(cmp_en),
        .cmp_bk(cmp_bk), .cmp_word(cmp_word), .any_hit(any_hit),
        .win_idx(win_idx), .win_bk(win_bk)
    );

    fpc_ctrl #(
        .ADDR_W(ADDR_W), .SEL_W(SEL_W), .BASE_W(BASE_W)
    ) ctrl_i (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .any_hit(any_hit), .win_idx(win_idx), .win_bk(win_bk),
        .glb_en(glb_en), .base_hi(base_hi), .res_valid(res_valid),
        .res_addr(res_addr), .remap_hit(remap_hit), .bkpt_pulse(bkpt_pulse)
    );

endmodule

// File: rtl/fpc_chk.sv
module fpc_chk #(
    parameter int unsigned        ADDR_W   = 32,
    parameter logic [ADDR_W-1:0]  CODE_TOP = 32'h2000_0000
) (
    input logic               clk,
    input logic               rst_n,
    input logic               acc_valid,
    input logic [ADDR_W-1:0]  acc_addr,
    input logic               res_valid,
    input logic [ADDR_W-1:0]  res_addr,
    input logic               remap_hit,
    input logic               bkpt_pulse,
    input logic               glb_en
);
    // R2
    result_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> res_valid);

    // R2
    no_spurious_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !res_valid);

    // R6
    remap_bkpt_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(remap_hit && bkpt_pulse));

    // R2
    flags_need_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (remap_hit || bkpt_pulse) |-> res_valid);

    // R9
    global_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !glb_en) |=> (!remap_hit && !bkpt_pulse));

    // R7
    outside_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_addr >= CODE_TOP) |=>
            (!remap_hit && !bkpt_pulse && res_addr == $past(acc_addr)));

    // R5
    remap_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid ##1 remap_hit) |-> (res_addr[1:0] == $past(acc_addr[1:0])));

    // R6
    bkpt_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid ##1 bkpt_pulse) |-> (res_addr == $past(acc_addr)));

endmodule

bind fpatch_cmp fpc_chk #(.ADDR_W(ADDR_W), .CODE_TOP(CODE_TOP)) chk_i (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .res_valid(res_valid), .res_addr(res_addr), .remap_hit(remap_hit),
    .bkpt_pulse(bkpt_pulse), .glb_en(glb_en)
);

// File: tb/fpatch_cmp_tb_top.sv
module fpatch_cmp_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NCMP = 8;
    localparam int NINSN = 6;
    localparam logic [31:0] CODE_TOP = 32'h2000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic        acc_valid = 1'b0;
    logic        acc_is_lit = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        res_valid, remap_hit, bkpt_pulse, glb_en;
    logic [31:0] res_addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench-side model of the programmed state
    bit          m_en [NCMP];
    bit          m_bk [NCMP];
    logic [29:0] m_word [NCMP];
    logic [31:0] m_base = '0;
    bit          m_glb = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fpatch_cmp dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .acc_valid(acc_valid), .acc_is_lit(acc_is_lit),
        .acc_addr(acc_addr), .res_valid(res_valid), .res_addr(res_addr),
        .remap_hit(remap_hit), .bkpt_pulse(bkpt_pulse), .glb_en(glb_en)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int idx, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 4'(idx); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (idx < NCMP) begin
            m_en[idx] = d[0]; m_bk[idx] = d[1]; m_word[idx] = d[31:2];
        end else if (idx == NCMP) begin
            m_base = d & 32'hFFFF_FFE0;
        end else if (idx == NCMP + 1) begin
            m_glb = d[0];
        end
    endtask

    function automatic logic [33:0] model(input bit lit, input logic [31:0] a);
        // returns {remap, bkpt, addr}
        for (int i = 0; i < NCMP; i++) begin
            bit grp = (i < NINSN) ? !lit : lit;
            if (m_glb && m_en[i] && grp && a < CODE_TOP && m_word[i] == a[31:2]) begin
                if (m_bk[i]) return {2'b01, a};
                return {2'b10, m_base + 32'(i * 4) + {30'd0, a[1:0]}};
            end
        end
        return {2'b00, a};
    endfunction

    task automatic acc(input bit lit, input logic [31:0] a, input string tag);
        logic [33:0] e;
        e = model(lit, a);
        @(negedge clk);
        acc_valid = 1'b1; acc_is_lit = lit; acc_addr = a;
        @(negedge clk);
        acc_valid = 1'b0;
        chk({res_valid, remap_hit, bkpt_pulse, res_addr} == {1'b1, e}, tag,
            64'({res_valid, remap_hit, bkpt_pulse, res_addr}), 64'({1'b1, e}));
    endtask

    task automatic clear_all();
        for (int i = 0; i < NCMP; i++) wr(i, 32'h0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NCMP; i++) begin m_en[i] = 0; m_bk[i] = 0; m_word[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(glb_en == 1'b0, "R1 glb_en", 64'(glb_en), 64'(0));
        chk(res_valid == 1'b0, "R1 res_valid", 64'(res_valid), 64'(0));
        wr(NCMP + 1, 32'h1);
        acc(1'b0, 32'h0000_0000, "R1 comparators disabled fetch");
        acc(1'b1, 32'h0000_0002, "R1 comparators disabled literal");
        wr(0, 32'h0000_0001);
        acc(1'b0, 32'h0000_0003, "R1 remap base zero");
        clear_all();

        // R2: idle after a result
        @(negedge clk);
        chk(res_valid == 1'b0, "R2 idle", 64'(res_valid), 64'(0));

        // R3 R4 R5 R11: sweep every comparator, both groups, all offsets (remap)
        wr(NCMP, 32'h2000_0117);
        for (int i = 0; i < NCMP; i++) begin
            clear_all();
            wr(i, (32'h0000_1000 + 32'(i) * 32'h40) | 32'h1);
            for (int off = 0; off < 4; off++) begin
                acc(1'b0, 32'h0000_1000 + 32'(i) * 32'h40 + 32'(off), "R3 R4 R5 fetch sweep");
                acc(1'b1, 32'h0000_1000 + 32'(i) * 32'h40 + 32'(off), "R3 R4 R5 literal sweep");
            end
            acc(1'b0, 32'h0000_1004 + 32'(i) * 32'h40, "R11 neighbour word");
        end

        // R6: breakpoint mode sweep
        for (int i = 0; i < NCMP; i++) begin
            clear_all();
            wr(i, (32'h0000_2000 + 32'(i) * 32'h40) | 32'h3);
            acc(1'b0, 32'h0000_2001 + 32'(i) * 32'h40, "R6 bkpt fetch");
            acc(1'b1, 32'h0000_2002 + 32'(i) * 32'h40, "R6 bkpt literal");
            @(negedge clk);
            chk(bkpt_pulse == 1'b0, "R6 single pulse", 64'(bkpt_pulse), 64'(0));
        end

        // R8: all comparators on one word, peel off lowest index one at a time
        for (int i = 0; i < NCMP; i++) wr(i, 32'h0000_0400 | ((i % 3 == 2) ? 32'h3 : 32'h1));
        for (int i = 0; i < NCMP; i++) begin
            acc(1'b0, 32'h0000_0401, "R8 fetch priority");
            acc(1'b1, 32'h0000_0402, "R8 literal priority");
            wr(i, 32'h0000_0400);
        end

        // R7: region boundary
        clear_all();
        wr(0, 32'h2000_0001);
        wr(1, 32'h1FFF_FFFD);
        wr(6, 32'h2000_0001);
        acc(1'b0, 32'h2000_0000, "R7 fetch at boundary");
        acc(1'b1, 32'h2000_0003, "R7 literal at boundary");
        acc(1'b0, 32'h1FFF_FFFE, "R7 last code word hits");

        // R2: back-to-back strobes
        @(negedge clk);
        acc_valid = 1'b1; acc_is_lit = 1'b0; acc_addr = 32'h1FFF_FFFC;
        @(negedge clk);
        chk(res_valid && remap_hit && res_addr == m_base + 32'd4, "R2 first of pair",
            64'({res_valid, remap_hit, res_addr}), 64'({2'b11, m_base + 32'd4}));
        acc_addr = 32'h0000_0010;
        @(negedge clk);
        acc_valid = 1'b0;
        chk(res_valid && !remap_hit && res_addr == 32'h0000_0010, "R2 second of pair",
            64'({res_valid, remap_hit, res_addr}), 64'({2'b10, 32'h0000_0010}));

        // R10: unused write indices change nothing
        for (int k = 10; k < 16; k++) wr(k, 32'h0000_0000);
        chk(glb_en == 1'b1, "R10 unused index keeps glb_en", 64'(glb_en), 64'(1));
        acc(1'b0, 32'h1FFF_FFFC, "R10 unused index keeps config");

        // R9: global enable off
        wr(NCMP + 1, 32'h0);
        chk(glb_en == 1'b0, "R9 glb_en cleared", 64'(glb_en), 64'(0));
        acc(1'b0, 32'h1FFF_FFFC, "R9 gated remap");
        wr(2, 32'h0000_0803);
        acc(1'b0, 32'h0000_0800, "R9 gated bkpt");
        wr(NCMP + 1, 32'h1);
        acc(1'b0, 32'h0000_0800, "R9 re-enabled bkpt");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule